// File: doc/BRIEF.md
# Split-Capable Load/Store Unit

This unit sits between a core pipeline and a single data-memory port one word wide. It takes one byte, halfword or word load or store at a time and turns it into memory transactions on a request/grant/valid handshake with byte enables. When an access would straddle a word boundary, the unit splits it into two word-aligned transactions. It places the write data on the correct byte lanes, and for loads it joins the returned words into one right-aligned result, sign- or zero-extended.

The pipeline presents a base address, an offset and a post-increment flag. With post-increment the memory is accessed at the base and the unit returns base plus offset as the updated address. Without it, both the access address and the returned address are base plus offset. `busy_o` tells the pipeline to hold off. A one-cycle `done_o` marks completion, and on loads `rdata_o` is valid in that same cycle.

Top module: `lsu_split`

## Requirements
- R1: An operation is accepted on a rising clock edge where `op_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle until completion. `op_size_i` selects the width: 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. While `busy_o` is low, `mem_req_o` is low.
- R2: Every issued transaction has an address whose two low bits are zero. `mem_be_o` bit i marks byte lane i, and it marks exactly the bytes of the access that fall in that word.
- R3: Once `mem_req_o` is raised, it stays high, and `mem_addr_o`, `mem_we_o`, `mem_be_o` and `mem_wdata_o` stay unchanged, up to and including the cycle in which `mem_gnt_i` is high.
- R4: The grant may come in the request cycle or any number of cycles later. Read data is taken in the cycle where `mem_rvalid_i` is high, however long after the grant. A load completes with `done_o` high and `busy_o` low in the cycle after its last valid: 3 cycles from the input cycle when both answers come at once.
- R5: An access whose bytes cross a word boundary becomes two transactions. The first goes to the word holding the start address and enables the lanes from the start offset upward. The second goes to the next word (address + 4) and enables only the remaining low lanes.
- R6: Byte k of the store operand, with byte 0 as the least significant, is written to the memory byte at access address + k.
- R7: A load returns in bit 0 upward the memory bytes from the access address upward, including bytes taken from the second word of a split access.
- R8: When `op_signed_i` is high, byte and halfword results fill the upper bits with the top loaded bit. When it is low, they fill them with zeros.
- R9: With `op_postinc_i` high, the access goes to `op_base_i`. With it low, the access goes to `op_base_i + op_offset_i`. In both cases `upd_addr_o` shows `op_base_i + op_offset_i` from the cycle after acceptance.
- R10: A store completes with `done_o` high and `busy_o` low in the cycle after its last grant: 2 cycles from the input cycle when an unsplit store is granted at once, 3 cycles when a split one is.
- R11: While reset is high, and in the cycle after it, `busy_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation request from the pipeline |
| op_we_i | input | 1 | 1 = store, 0 = load |
| op_size_i | input | 2 | Access width code |
| op_signed_i | input | 1 | Sign-extend load result |
| op_postinc_i | input | 1 | Access at base, return base + offset |
| op_base_i | input | 32 | Base address |
| op_offset_i | input | 32 | Address offset |
| op_wdata_i | input | 32 | Store operand, right-aligned |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | 32 | Load result, valid with done_o |
| upd_addr_o | output | 32 | Base plus offset |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-shifted write data |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The accesses exercised are word, byte and halfword accesses at aligned offsets, at the top lane, and across a word boundary. They are run first against a memory that answers at once and then against one that delays both grant and valid by three cycles. The immediate memory pins down the exact completion latency of each path, so a skipped or extra state shows up as a cycle difference. The slow memory shows whether the request fields are held while the grant is pending. Byte loads of a value with its top bit set, done signed and unsigned, separate sign from zero extension. Reading a straddled word back both whole and as its two aligned halves separates lane placement from merging. Post-increment and plain offset accesses to the same base tell the two address sources apart.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_align.sv
// Lane placement for one access: byte enables and write data over two words.
module lsu_align #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SZ_W-1:0]   size_eff_o,
  output logic [BYTES-1:0]  be_lo_o,
  output logic [BYTES-1:0]  be_hi_o,
  output logic [DATA_W-1:0] wd_lo_o,
  output logic [DATA_W-1:0] wd_hi_o,
  output logic              split_o
);
  logic [2*BYTES-1:0]  mask_base;
  logic [2*BYTES-1:0]  mask_sh;
  logic [2*DATA_W-1:0] data_sh;
  int                  nbytes;

  always_comb begin
    size_eff_o = (int'(size_i) > OFF_W) ? SZ_W'(OFF_W) : size_i;
    nbytes     = 1 << size_eff_o;
    for (int i = 0; i < 2*BYTES; i++) mask_base[i] = (i < nbytes);
    mask_sh = mask_base << off_i;
    data_sh = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};
    be_lo_o = mask_sh[BYTES-1:0];
    be_hi_o = mask_sh[2*BYTES-1:BYTES];
    wd_lo_o = data_sh[DATA_W-1:0];
    wd_hi_o = data_sh[2*DATA_W-1:DATA_W];
    split_o = |mask_sh[2*BYTES-1:BYTES];
  end
endmodule

// File: rtl/lsu_merge.sv
// Joins one or two returned words, right-aligns and extends the result.
module lsu_merge #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] sh;
  logic              fill;
  int                nb;

  always_comb begin
    sh   = DATA_W'({hi_i, lo_i} >> {off_i, 3'b000});
    nb   = 1 << size_i;
    fill = signed_i && sh[8*nb-1];
    for (int i = 0; i < BYTES; i++)
      result_o[8*i +: 8] = (i < nb) ? sh[8*i +: 8] : {8{fill}};
  end
endmodule

// File: rtl/lsu_split.sv
module lsu_split
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic              op_we_i,
  input  logic [SZ_W-1:0]   op_size_i,
  input  logic              op_signed_i,
  input  logic              op_postinc_i,
  input  logic [ADDR_W-1:0] op_base_i,
  input  logic [ADDR_W-1:0] op_offset_i,
  input  logic [DATA_W-1:0] op_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  lsu_state_e        state_q;
  logic [ADDR_W-1:0] sum_addr, acc_addr;
  logic [SZ_W-1:0]   a_size;
  logic [BYTES-1:0]  a_be_lo, a_be_hi;
  logic [DATA_W-1:0] a_wd_lo, a_wd_hi;
  logic              a_split;

  logic [BYTES-1:0]  be_hi_q;
  logic [DATA_W-1:0] wd_hi_q, lo_word_q;
  logic              split_q, second_q, signed_q;
  logic [OFF_W-1:0]  off_q;
  logic [SZ_W-1:0]   size_q;
  logic [DATA_W-1:0] merge_lo, merge_hi, merged;
  logic              accept;

  assign sum_addr = op_base_i + op_offset_i;
  assign acc_addr = op_postinc_i ? op_base_i : sum_addr;
  assign accept   = op_valid_i && (state_q == ST_IDLE);

  lsu_align #(.DATA_W(DATA_W)) i_align (
    .off_i      (acc_addr[OFF_W-1:0]),
    .size_i     (op_size_i),
    .wdata_i    (op_wdata_i),
    .size_eff_o (a_size),
    .be_lo_o    (a_be_lo),
    .be_hi_o    (a_be_hi),
    .wd_lo_o    (a_wd_lo),
    .wd_hi_o    (a_wd_hi),
    .split_o    (a_split)
  );

  assign merge_lo = split_q ? lo_word_q : mem_rdata_i;
  assign merge_hi = split_q ? mem_rdata_i : '0;

  lsu_merge #(.DATA_W(DATA_W)) i_merge (
    .lo_i     (merge_lo),
    .hi_i     (merge_hi),
    .off_i    (off_q),
    .size_i   (size_q),
    .signed_i (signed_q),
    .result_o (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
      upd_addr_o  <= '0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      be_hi_q     <= '0;
      wd_hi_q     <= '0;
      lo_word_q   <= '0;
      split_q     <= 1'b0;
      second_q    <= 1'b0;
      signed_q    <= 1'b0;
      off_q       <= '0;
      size_q      <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_REQ;
            busy_o      <= 1'b1;
            mem_req_o   <= 1'b1;
            mem_addr_o  <= {acc_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            mem_we_o    <= op_we_i;
            mem_be_o    <= a_be_lo;
            mem_wdata_o <= a_wd_lo;
            be_hi_q     <= a_be_hi;
            wd_hi_q     <= a_wd_hi;
            split_q     <= a_split;
            second_q    <= 1'b0;
            signed_q    <= op_signed_i;
            off_q       <= acc_addr[OFF_W-1:0];
            size_q      <= a_size;
            upd_addr_o  <= sum_addr;
          end
        end
        ST_REQ: begin
          if (mem_gnt_i) begin
            if (!mem_we_o) begin
              mem_req_o <= 1'b0;
              state_q   <= ST_WAIT;
            end else if (split_q && !second_q) begin
              second_q    <= 1'b1;
              mem_addr_o  <= mem_addr_o + ADDR_W'(BYTES);
              mem_be_o    <= be_hi_q;
              mem_wdata_o <= wd_hi_q;
            end else begin
              mem_req_o <= 1'b0;
              state_q   <= ST_IDLE;
              busy_o    <= 1'b0;
              done_o    <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (split_q && !second_q) begin
              lo_word_q  <= mem_rdata_i;
              second_q   <= 1'b1;
              mem_addr_o <= mem_addr_o + ADDR_W'(BYTES);
              mem_be_o   <= be_hi_q;
              mem_req_o  <= 1'b1;
              state_q    <= ST_REQ;
            end else begin
              rdata_o <= merged;
              state_q <= ST_IDLE;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: request fields frozen while the grant is outstanding
  p_hold_until_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_be_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R2: word-aligned address and at least one lane per transaction
  p_word_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0 && mem_be_o != '0));

  // R1: no memory traffic while the unit reports idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);

  // R1: acceptance raises busy on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !busy_o) |=> busy_o);

  // R4: completion ends a busy period
  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/test_lsu_split.sv
`timescale 1ns/1ps
module test_lsu_split;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0, op_we_i = 1'b0, op_signed_i = 1'b0, op_postinc_i = 1'b0;
  logic [1:0]  op_size_i = 2'd0;
  logic [31:0] op_base_i = '0, op_offset_i = '0, op_wdata_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [31:0] rdata_o, upd_addr_o, mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int checks = 0, errors = 0, cycles = 0;
  int gnt_lat = 0, rv_lat = 1;
  int wait_cnt = 0, rv_cnt = 0, txn_cnt = 0, stab_err = 0;
  logic [31:0] mem [16];
  logic [31:0] log_addr [4];
  logic [3:0]  log_be [4];
  logic [3:0]  rd_idx;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr, prev_wd;
  logic [3:0]  prev_be;

  always #2.5 clk = ~clk;

  lsu_split i_lsu_split (
    .clk, .rst, .op_valid_i, .op_we_i, .op_size_i, .op_signed_i, .op_postinc_i,
    .op_base_i, .op_offset_i, .op_wdata_i, .busy_o, .done_o, .rdata_o, .upd_addr_o,
    .mem_req_o, .mem_addr_o, .mem_we_o, .mem_be_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i
  );

  // memory model, acts away from the active edge
  always @(negedge clk) begin
    mem_gnt_i    = 1'b0;
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = 32'hDEAD_BEEF;
    if (rv_cnt > 0) begin
      rv_cnt = rv_cnt - 1;
      if (rv_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem[rd_idx];
      end
    end
    if (mem_req_o && prev_pend &&
        (mem_addr_o != prev_addr || mem_be_o != prev_be || mem_wdata_o != prev_wd))
      stab_err++;
    if (mem_req_o) begin
      if (wait_cnt >= gnt_lat) begin
        mem_gnt_i = 1'b1;
        wait_cnt  = 0;
        if (txn_cnt < 4) begin
          log_addr[txn_cnt] = mem_addr_o;
          log_be[txn_cnt]   = mem_be_o;
        end
        txn_cnt++;
        if (mem_we_o) begin
          for (int i = 0; i < 4; i++)
            if (mem_be_o[i]) mem[mem_addr_o[5:2]][8*i +: 8] = mem_wdata_o[8*i +: 8];
        end else begin
          rd_idx = mem_addr_o[5:2];
          rv_cnt = rv_lat;
        end
      end else begin
        wait_cnt++;
      end
    end
    prev_pend = mem_req_o && !mem_gnt_i;
    prev_addr = mem_addr_o;
    prev_be   = mem_be_o;
    prev_wd   = mem_wdata_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog: actual no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit we, input logic [1:0] sz, input bit sgn, input bit pinc,
                        input logic [31:0] base, input logic [31:0] offs,
                        input logic [31:0] wd, output int lat, output bit busy_seen);
    @(negedge clk);
    op_valid_i = 1'b1; op_we_i = we; op_size_i = sz; op_signed_i = sgn;
    op_postinc_i = pinc; op_base_i = base; op_offset_i = offs; op_wdata_i = wd;
    txn_cnt = 0;
    @(negedge clk);
    op_valid_i = 1'b0;
    busy_seen = busy_o;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    chk(!busy_o, "R11 busy after reset", {31'b0, busy_o}, 0);
    chk(!done_o, "R11 done after reset", {31'b0, done_o}, 0);
    chk(!mem_req_o, "R11 req after reset", {31'b0, mem_req_o}, 0);
  endtask

  task automatic t_word;
    int lat; bit b;
    run_op(1, 2'd2, 0, 0, 32'h10, 0, 32'h1122_3344, lat, b);
    chk(lat == 2, "R10 aligned store latency", lat, 2);
    chk(log_be[0] == 4'hF && log_addr[0] == 32'h10, "R2 word store lanes", {log_addr[0][27:0], log_be[0]}, 32'h0000_010F);
    run_op(0, 2'd2, 0, 0, 32'h10, 0, 0, lat, b);
    chk(b, "R1 busy after accept", {31'b0, b}, 1);
    chk(lat == 3, "R4 aligned load latency", lat, 3);
    chk(rdata_o == 32'h1122_3344, "R7 word load", rdata_o, 32'h1122_3344);
  endtask

  task automatic t_byte;
    int lat; bit b;
    run_op(1, 2'd0, 0, 0, 32'h10, 3, 32'hFFFF_FFA5, lat, b);
    chk(log_be[0] == 4'b1000 && txn_cnt == 1, "R2 byte lane 3", {28'b0, log_be[0]}, 32'h8);
    run_op(0, 2'd2, 0, 0, 32'h10, 0, 0, lat, b);
    chk(rdata_o == 32'hA522_3344, "R6 byte placement", rdata_o, 32'hA522_3344);
    run_op(0, 2'd0, 1, 0, 32'h13, 0, 0, lat, b);
    chk(rdata_o == 32'hFFFF_FFA5, "R8 signed byte", rdata_o, 32'hFFFF_FFA5);
    run_op(0, 2'd0, 0, 0, 32'h13, 0, 0, lat, b);
    chk(rdata_o == 32'h0000_00A5, "R8 unsigned byte", rdata_o, 32'h0000_00A5);
  endtask

  task automatic t_split;
    int lat; bit b;
    run_op(1, 2'd2, 0, 0, 32'h16, 0, 32'hCAFE_F00D, lat, b);
    chk(txn_cnt == 2, "R5 split store count", txn_cnt, 2);
    chk(log_addr[0] == 32'h14 && log_be[0] == 4'b1100, "R5 first half", {log_addr[0][27:0], log_be[0]}, 32'h0000_014C);
    chk(log_addr[1] == 32'h18 && log_be[1] == 4'b0011, "R5 second half", {log_addr[1][27:0], log_be[1]}, 32'h0000_0183);
    chk(lat == 3, "R10 split store latency", lat, 3);
    run_op(0, 2'd2, 0, 0, 32'h14, 0, 0, lat, b);
    chk(rdata_o == 32'hF00D_0000, "R6 lanes of first word", rdata_o, 32'hF00D_0000);
    run_op(0, 2'd2, 0, 0, 32'h16, 0, 0, lat, b);
    chk(rdata_o == 32'hCAFE_F00D, "R7 split word merge", rdata_o, 32'hCAFE_F00D);
    chk(lat == 5, "R4 split load latency", lat, 5);
    run_op(0, 2'd1, 1, 0, 32'h17, 0, 0, lat, b);
    chk(txn_cnt == 2 && rdata_o == 32'hFFFF_FEF0, "R8 signed split half", rdata_o, 32'hFFFF_FEF0);
  endtask

  task automatic t_slow;
    int lat; bit b;
    gnt_lat = 3; rv_lat = 3; stab_err = 0;
    run_op(0, 2'd2, 0, 0, 32'h10, 0, 0, lat, b);
    chk(lat == 8, "R4 delayed grant and valid latency", lat, 8);
    chk(rdata_o == 32'hA522_3344, "R4 delayed load data", rdata_o, 32'hA522_3344);
    run_op(1, 2'd2, 0, 0, 32'h26, 0, 32'h8765_4321, lat, b);
    run_op(0, 2'd2, 0, 0, 32'h26, 0, 0, lat, b);
    chk(rdata_o == 32'h8765_4321, "R5 slow split round trip", rdata_o, 32'h8765_4321);
    chk(stab_err == 0, "R3 fields held until grant", stab_err, 0);
    gnt_lat = 0; rv_lat = 1;
  endtask

  task automatic t_postinc;
    int lat; bit b;
    run_op(1, 2'd2, 0, 1, 32'h30, 8, 32'h5A5A_0001, lat, b);
    chk(log_addr[0] == 32'h30, "R9 postinc access at base", log_addr[0], 32'h30);
    chk(upd_addr_o == 32'h38, "R9 postinc updated address", upd_addr_o, 32'h38);
    run_op(0, 2'd2, 0, 0, 32'h30, 8, 0, lat, b);
    chk(log_addr[0] == 32'h38, "R9 offset access", log_addr[0], 32'h38);
    run_op(0, 2'd2, 0, 1, 32'h30, 32'hFFFF_FFFC, 0, lat, b);
    chk(rdata_o == 32'h5A5A_0001 && upd_addr_o == 32'h2C, "R9 negative postinc", upd_addr_o, 32'h2C);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word();
    t_byte();
    t_split();
    t_slow();
    t_postinc();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule